// File: doc/BRIEF.md
# Upstream Signalling Octet Assembler

The block builds the signalling/control octet that a two-channel line-interface device sends upstream in every frame of a four-byte serial control channel. Each channel has three input-capable detector and control pins. The first detector has its level debounced over a set number of frames. The second detector is majority-filtered over recent frames. The third pin is sampled as it stands. The six channel bits are packed with the two monitor handshake bits into one octet. The octet is latched at the start of its byte slot and shifted out most significant bit first.

Each of the six channel bits has its own direction setting. A bit whose pin is set as an input carries the conditioned pin level. A bit whose pin is set as an output echoes the matching bit most recently received from downstream. The source for the second detector is chosen by a demultiplex mode input: it is either the normal second detector pin or an alternate first-detector pin. The handshake bits are produced elsewhere and arrive as plain inputs.

Top module: `ciUpstreamAssembler`

## Requirements
- R1: `octetOut` bit 7 down to bit 0 holds: channel-1 C3, channel-1 CDB, channel-1 CDA, channel-2 C3, channel-2 CDB, channel-2 CDA, `mrBit`, `mxBit`. Index 0 of each per-channel pin vector is channel 1.
- R2: A `slotStart` cycle latches the assembled octet into `octetOut`. In the next cycle `serOut` shows bit 7. Each later `bitTick` moves `serOut` to the next lower bit. After the eighth `bitTick` `serOut` returns to 1, and `serOut` is also 1 whenever no slot is being shifted. `octetOut` changes only on `slotStart`.
- R3: `dirIn[i]` = 1 marks the pin of octet bit i+2 as an input, and that bit then carries the conditioned pin value.
- R4: `dirIn[i]` = 0 makes octet bit i+2 carry `dsCi[i]`, as captured on the latest `dsValid` cycle.
- R5: The CDA value changes only after the raw pin has differed from it on DEB_FRAMES consecutive `frameSync` samples. The default is 2.
- R6: The CDB value is the majority of the last three `frameSync` samples of `cd2Pin`, or of `cd1bPin` while `e1Demux` = 1.
- R7: The C3 value is the `c3Pin` level captured at the latest `frameSync`.
- R8: Pin levels have no effect except in cycles with `frameSync` = 1.
- R9: After reset `octetOut` = 0, `serOut` = 1, and the debounce, filter, C3 and echo state are all 0.
- R10: When `frameSync` and `slotStart` fall in the same cycle, the latched octet uses the conditioned values from before that frame's sample.
- R11: A `slotStart` that arrives while a slot is shifting restarts the shift from bit 7 of the new octet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Frame strobe; samples the pins |
| slotStart | input | 1 | Start of the upstream signalling byte slot |
| bitTick | input | 1 | Advance the serial output by one bit |
| cdaPin | input | 2 | First detector pins, per channel |
| cd2Pin | input | 2 | Second detector pins, per channel |
| cd1bPin | input | 2 | Alternate first-detector pins used in demultiplex mode |
| c3Pin | input | 2 | Third control pins, per channel |
| e1Demux | input | 1 | Selects `cd1bPin` as the CDB source |
| dirIn | input | 6 | Per-bit direction, 1 = input |
| dsValid | input | 1 | Downstream C/I bits valid |
| dsCi | input | 6 | Downstream C/I bits, bit i matching octet bit i+2 |
| mrBit | input | 1 | Monitor receive handshake bit |
| mxBit | input | 1 | Monitor transmit handshake bit |
| octetOut | output | 8 | Octet latched for the current slot |
| serOut | output | 1 | Serial upstream bit, MSB first |

## Verification
Frame sampling and slot latching can land on the same edge. The bench provokes this both directly and at random. It expects the latched octet to reflect the state before that frame's sample, and the newly sampled levels only from the next slot on. A new slot that starts in the middle of shifting is the second collision. The bench drives it and expects bit 7 of the new octet on the following cycle. The echo registers are loaded in the same cycle as a latch, which also exercises old-value selection for output-direction bits.

// File: rtl/ciPkg.sv
package ciPkg;
  typedef struct packed {
    logic sample;
    logic load;
    logic shift;
    logic echo;
  } ciStrobes_t;
endpackage

// File: rtl/ciControl.sv
module ciControl
  import ciPkg::*;
#(
  parameter int OCTET_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic       slotStart,
  input  logic       bitTick,
  input  logic       dsValid,
  output ciStrobes_t strobes,
  output logic       shiftActive
);
  localparam int CNT_W = $clog2(OCTET_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OCTET_W - 1);

  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strobes.sample = frameSync;
    strobes.load   = slotStart;
    strobes.shift  = bitTick && shiftActive && !slotStart;
    strobes.echo   = dsValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftActive <= 1'b0;
      bitCnt      <= '0;
    end else if (slotStart) begin
      shiftActive <= 1'b1;
      bitCnt      <= '0;
    end else if (bitTick && shiftActive) begin
      if (bitCnt == LAST_BIT) begin
        shiftActive <= 1'b0;
        bitCnt      <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ciDebounce.sv
module ciDebounce #(
  parameter int FRAMES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleEn,
  input  logic rawIn,
  output logic level
);
  localparam int CNT_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAMES - 1);

  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level  <= 1'b0;
      runCnt <= '0;
    end else if (sampleEn) begin
      if (rawIn == level) begin
        runCnt <= '0;
      end else if (runCnt == LIMIT) begin
        level  <= rawIn;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ciDatapath.sv
module ciDatapath
  import ciPkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int DEB_FRAMES = 2,
  parameter int VOTE_DEPTH = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ciStrobes_t            strobes,
  input  logic                  shiftActive,
  input  logic [NUM_CH-1:0]     cdaPin,
  input  logic [NUM_CH-1:0]     cd2Pin,
  input  logic [NUM_CH-1:0]     cd1bPin,
  input  logic [NUM_CH-1:0]     c3Pin,
  input  logic                  e1Demux,
  input  logic [3*NUM_CH-1:0]   dirIn,
  input  logic [3*NUM_CH-1:0]   dsCi,
  input  logic                  mrBit,
  input  logic                  mxBit,
  output logic [3*NUM_CH-1:0]   condBits,
  output logic [3*NUM_CH-1:0]   echoBits,
  output logic [3*NUM_CH+1:0]   octetOut,
  output logic                  serOut
);
  localparam int CI_W     = 3 * NUM_CH;
  localparam int OCTET_W  = CI_W + 2;
  localparam int VOTE_MIN = VOTE_DEPTH / 2 + 1;

  logic [NUM_CH-1:0]  cdaLvl;
  logic [NUM_CH-1:0]  cdbLvl;
  logic [NUM_CH-1:0]  c3Lvl;
  logic [CI_W-1:0]    selBits;
  logic [OCTET_W-1:0] nextOctet;
  logic [OCTET_W-1:0] shiftReg;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [VOTE_DEPTH-1:0] voteHist;
    logic                  c3Samp;

    ciDebounce #(.FRAMES(DEB_FRAMES)) u_deb (
      .clk     (clk),
      .rstN    (rstN),
      .sampleEn(strobes.sample),
      .rawIn   (cdaPin[ch]),
      .level   (cdaLvl[ch])
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        voteHist <= '0;
        c3Samp   <= 1'b0;
      end else if (strobes.sample) begin
        voteHist <= {voteHist[VOTE_DEPTH-2:0], e1Demux ? cd1bPin[ch] : cd2Pin[ch]};
        c3Samp   <= c3Pin[ch];
      end
    end

    assign cdbLvl[ch] = ($countones(voteHist) >= VOTE_MIN);
    assign c3Lvl[ch]  = c3Samp;
  end

  always_comb begin
    condBits = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      condBits[CI_W-1-3*ch] = c3Lvl[ch];
      condBits[CI_W-2-3*ch] = cdbLvl[ch];
      condBits[CI_W-3-3*ch] = cdaLvl[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) echoBits <= '0;
    else if (strobes.echo) echoBits <= dsCi;
  end

  assign selBits   = (dirIn & condBits) | (~dirIn & echoBits);
  assign nextOctet = {selBits, mrBit, mxBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      octetOut <= '0;
      shiftReg <= '1;
    end else if (strobes.load) begin
      octetOut <= nextOctet;
      shiftReg <= nextOctet;
    end else if (strobes.shift) begin
      shiftReg <= {shiftReg[OCTET_W-2:0], 1'b1};
    end
  end

  assign serOut = shiftActive ? shiftReg[OCTET_W-1] : 1'b1;
endmodule

// File: rtl/ciUpstreamAssembler.sv
module ciUpstreamAssembler
  import ciPkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int DEB_FRAMES = 2,
  parameter int VOTE_DEPTH = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameSync,
  input  logic                slotStart,
  input  logic                bitTick,
  input  logic [NUM_CH-1:0]   cdaPin,
  input  logic [NUM_CH-1:0]   cd2Pin,
  input  logic [NUM_CH-1:0]   cd1bPin,
  input  logic [NUM_CH-1:0]   c3Pin,
  input  logic                e1Demux,
  input  logic [3*NUM_CH-1:0] dirIn,
  input  logic                dsValid,
  input  logic [3*NUM_CH-1:0] dsCi,
  input  logic                mrBit,
  input  logic                mxBit,
  output logic [3*NUM_CH+1:0] octetOut,
  output logic                serOut
);
  localparam int CI_W    = 3 * NUM_CH;
  localparam int OCTET_W = CI_W + 2;

  ciStrobes_t      strobes;
  logic            shiftActive;
  logic [CI_W-1:0] condBits;
  logic [CI_W-1:0] echoBits;

  ciControl #(.OCTET_W(OCTET_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameSync  (frameSync),
    .slotStart  (slotStart),
    .bitTick    (bitTick),
    .dsValid    (dsValid),
    .strobes    (strobes),
    .shiftActive(shiftActive)
  );

  ciDatapath #(
    .NUM_CH    (NUM_CH),
    .DEB_FRAMES(DEB_FRAMES),
    .VOTE_DEPTH(VOTE_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .shiftActive(shiftActive),
    .cdaPin     (cdaPin),
    .cd2Pin     (cd2Pin),
    .cd1bPin    (cd1bPin),
    .c3Pin      (c3Pin),
    .e1Demux    (e1Demux),
    .dirIn      (dirIn),
    .dsCi       (dsCi),
    .mrBit      (mrBit),
    .mxBit      (mxBit),
    .condBits   (condBits),
    .echoBits   (echoBits),
    .octetOut   (octetOut),
    .serOut     (serOut)
  );
endmodule

// File: rtl/ciAssemblerChecks.sv
module ciAssemblerChecks #(
  parameter int CI_W = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            frameSync,
  input logic            slotStart,
  input logic [CI_W-1:0] dirIn,
  input logic            dsValid,
  input logic [CI_W-1:0] dsCi,
  input logic            mrBit,
  input logic            mxBit,
  input logic [CI_W-1:0] condBits,
  input logic [CI_W-1:0] echoBits,
  input logic [CI_W+1:0] octetOut,
  input logic            serOut
);
  a_r2_msb_first: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |=> serOut == octetOut[CI_W+1]);

  a_r2_octet_hold: assert property (@(posedge clk) disable iff (!rstN)
    !slotStart |=> $stable(octetOut));

  a_r1_handshake: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |=> octetOut[1:0] == $past({mrBit, mxBit}));

  a_r3_select: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |=> octetOut[CI_W+1:2] ==
      (($past(dirIn) & $past(condBits)) | (~$past(dirIn) & $past(echoBits))));

  a_r4_echo_load: assert property (@(posedge clk) disable iff (!rstN)
    dsValid |=> echoBits == $past(dsCi));

  a_r4_echo_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dsValid |=> $stable(echoBits));

  a_r8_pins_ignored: assert property (@(posedge clk) disable iff (!rstN)
    !frameSync |=> $stable(condBits));
endmodule

bind ciUpstreamAssembler ciAssemblerChecks #(.CI_W(CI_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .frameSync(frameSync),
  .slotStart(slotStart),
  .dirIn    (dirIn),
  .dsValid  (dsValid),
  .dsCi     (dsCi),
  .mrBit    (mrBit),
  .mxBit    (mxBit),
  .condBits (condBits),
  .echoBits (echoBits),
  .octetOut (octetOut),
  .serOut   (serOut)
);

// File: tb/sim_ciUpstreamAssembler.sv
module sim_ciUpstreamAssembler;
  localparam int DEB = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 0, slotStart = 0, bitTick = 0;
  logic [1:0] cdaPin = 0, cd2Pin = 0, cd1bPin = 0, c3Pin = 0;
  logic e1Demux = 0;
  logic [5:0] dirIn = 0;
  logic dsValid = 0;
  logic [5:0] dsCi = 0;
  logic mrBit = 0, mxBit = 0;
  logic [7:0] octetOut;
  logic serOut;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // bench reference state
  logic       mAcc[2];
  int         mCnt[2];
  logic [2:0] mHist[2];
  logic       mC3[2];
  logic [5:0] mEcho;
  logic [7:0] mOct, mSh;
  logic       mAct;
  int         mBit;

  always #5 clk = ~clk;

  ciUpstreamAssembler u0 (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .slotStart(slotStart),
    .bitTick(bitTick), .cdaPin(cdaPin), .cd2Pin(cd2Pin), .cd1bPin(cd1bPin),
    .c3Pin(c3Pin), .e1Demux(e1Demux), .dirIn(dirIn), .dsValid(dsValid),
    .dsCi(dsCi), .mrBit(mrBit), .mxBit(mxBit), .octetOut(octetOut), .serOut(serOut)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic maj3(input logic [2:0] h);
    return (h[0] + h[1] + h[2]) >= 2;
  endfunction

  function automatic logic [7:0] buildOctet();
    logic [5:0] cond;
    for (int c = 0; c < 2; c++) begin
      cond[5-3*c] = mC3[c];
      cond[4-3*c] = maj3(mHist[c]);
      cond[3-3*c] = mAcc[c];
    end
    return {(dirIn & cond) | (~dirIn & mEcho), mrBit, mxBit};
  endfunction

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mAcc[c] = 0; mCnt[c] = 0; mHist[c] = 0; mC3[c] = 0;
    end
    mEcho = 0; mOct = 0; mSh = 8'hFF; mAct = 0; mBit = 0;
  endtask

  task automatic modelStep();
    logic [7:0] cur;
    cur = buildOctet();
    if (slotStart) begin
      mOct = cur; mSh = cur; mAct = 1; mBit = 0;
    end else if (bitTick && mAct) begin
      mSh = {mSh[6:0], 1'b1};
      if (mBit == 7) begin mAct = 0; mBit = 0; end
      else mBit++;
    end
    if (frameSync) begin
      for (int c = 0; c < 2; c++) begin
        if (cdaPin[c] == mAcc[c]) mCnt[c] = 0;
        else if (mCnt[c] == DEB - 1) begin mAcc[c] = cdaPin[c]; mCnt[c] = 0; end
        else mCnt[c]++;
        mHist[c] = {mHist[c][1:0], e1Demux ? cd1bPin[c] : cd2Pin[c]};
        mC3[c] = c3Pin[c];
      end
    end
    if (dsValid) mEcho = dsCi;
  endtask

  // one clock: reference follows the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    chk(octetOut, mOct, "R1 R3 R4 R5 R6 R7 octet");
    chk({7'd0, serOut}, {7'd0, mAct ? mSh[7] : 1'b1}, "R2 R11 serial");
  endtask

  task automatic frame(); frameSync = 1; tick(); frameSync = 0; endtask
  task automatic slot();  slotStart = 1; tick(); slotStart = 0; endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] bits;
    logic [7:0] prev;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R9: reset state
    chk(octetOut, 8'h00, "R9 octet after reset");
    chk({7'd0, serOut}, 8'h01, "R9 serOut idle");

    // R5: debounce of ch1 CDA (octet bit 5)
    dirIn = 6'h3F;
    cdaPin = 2'b01;
    frame(); slot();
    chk({7'd0, octetOut[5]}, 8'h00, "R5 one frame not accepted");
    frame(); slot();
    chk({7'd0, octetOut[5]}, 8'h01, "R5 accepted after two frames");
    cdaPin = 2'b00; frame(); cdaPin = 2'b01; frame(); slot();
    chk({7'd0, octetOut[5]}, 8'h01, "R5 single-frame glitch rejected");

    // R6: majority filter on ch1 CDB (octet bit 6)
    cd2Pin = 2'b01;
    frame(); slot();
    chk({7'd0, octetOut[6]}, 8'h00, "R6 one of three");
    frame(); slot();
    chk({7'd0, octetOut[6]}, 8'h01, "R6 two of three");
    e1Demux = 1; cd1bPin = 2'b00;
    frame(); frame(); slot();
    chk({7'd0, octetOut[6]}, 8'h00, "R6 demux source selected");
    e1Demux = 0; cd2Pin = 2'b00;

    // R10: frame and slot collide, ch2 C3 (octet bit 4)
    c3Pin = 2'b10;
    frameSync = 1; slotStart = 1; tick(); frameSync = 0; slotStart = 0;
    chk({7'd0, octetOut[4]}, 8'h00, "R10 old value latched on collision");
    slot();
    chk({7'd0, octetOut[4]}, 8'h01, "R7 C3 sampled level");

    // R8: pins move without frameSync
    prev = octetOut;
    cdaPin = 2'b10; cd2Pin = 2'b11; c3Pin = 2'b01;
    tick(); tick(); slot();
    chk(octetOut, prev, "R8 pins ignored between frames");

    // R4: echo of downstream bits
    dirIn = 6'h00; dsCi = 6'b101001; dsValid = 1; tick(); dsValid = 0;
    dsCi = 6'b010110; mrBit = 1; mxBit = 0;
    slot();
    chk(octetOut, 8'b10100110, "R4 echo with R1 handshake bits");

    // R2: serial shift, MSB first
    bits[7] = serOut;
    bitTick = 1;
    for (int i = 6; i >= 0; i--) begin tick(); bits[i] = serOut; end
    tick(); bitTick = 0;
    chk(bits, 8'b10100110, "R2 serial bit order");
    chk({7'd0, serOut}, 8'h01, "R2 idle high after eight bits");

    // R11: restart during shifting
    dsCi = 6'b011111; dsValid = 1; tick(); dsValid = 0;
    slot();
    bitTick = 1; tick(); tick(); tick(); bitTick = 0;
    dsCi = 6'b100000; dsValid = 1; tick(); dsValid = 0;
    slot();
    chk({7'd0, serOut}, 8'h01, "R11 restart shows new bit 7");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      frameSync = ($urandom % 4) == 0;
      slotStart = ($urandom % 8) == 0;
      bitTick   = ($urandom % 2) == 0;
      dsValid   = ($urandom % 5) == 0;
      dsCi      = 6'($urandom);
      cdaPin    = 2'($urandom); cd2Pin = 2'($urandom);
      cd1bPin   = 2'($urandom); c3Pin  = 2'($urandom);
      mrBit     = 1'($urandom); mxBit  = 1'($urandom);
      if (($urandom % 50) == 0) dirIn = 6'($urandom);
      if (($urandom % 60) == 0) e1Demux = ~e1Demux;
      tick();
    end
    frameSync = 0; slotStart = 0; bitTick = 0; dsValid = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule